// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This block sits beside a simple in-order CPU pipeline and carries out the entry sequence for synchronous exceptions and the non-maskable interrupt. Each cycle it looks at the event request lines and the memory access now in flight. It picks the most urgent event that may be accepted. For that event it captures a resume PC and the current status word into their save registers and records the event code. It also raises the block, privileged-mode and register-bank bits in the status value it hands back. Finally it steers fetch to the vector base plus the event's offset.

The controller has two states. `ST_RUN` is the normal state. It moves to `ST_ENTER` on the edge where an eligible event is accepted, and it stays there for exactly one cycle. During that cycle `taken` is high, the pipeline flushes, and new exception requests are not looked at. `ST_ENTER` then always returns to `ST_RUN`. A rising edge on the NMI pin is caught in a pending flag. That flag is cleared only when the NMI is accepted.

Status bit positions used throughout: bit 28 is the block bit, bit 29 is the register-bank bit, and bit 30 is the privileged-mode bit. Access size encoding on `mem_size`: 0 = byte, 1 = word, 2 = longword.

Top module: `exc_entry_unit`

## Requirements
- R1: An access with `mem_req` high raises an address error in two cases: a word access whose address bits [1:0] are 1 or 3, or a longword access whose address bits [1:0] are not 0. Byte accesses never fault. The address error writes 0x5C0 to `expevt`, saves `cur_pc` into `spc`, and redirects to `vbr` + 0x100.
- R2: `slot_priv_req` is taken only while `sr_in` bit 30 is 0. It saves `branch_pc` into `spc`, writes 0x1A0 to `expevt`, and redirects to `vbr` + 0x100. While bit 30 is 1, the request has no effect.
- R3: A break request writes 0x1E0 to `expevt` and redirects to `vbr` + 0x100. With `brk_post` at 1 it saves `next_pc`; with `brk_post` at 0 it saves `cur_pc`.
- R4: A rising edge on `nmi_pin` is accepted whatever the value of the mask-level bits [7:4]. Acceptance writes 0x1C0 to both `intevt` and `intevt2`, saves `next_pc`, redirects to `vbr` + 0x600, and leaves `expevt` unchanged.
- R5: While `sr_in` bit 28 is 1 and `nmi_blk_override` is 0, a caught NMI edge is not taken but stays pending. It is taken once bit 28 falls, or at once if the override is 1.
- R6: When several events are eligible together, they are taken one per entry in this order: address error, delay-slot privilege fault, break, NMI.
- R7: Every entry copies `sr_in` into `ssr` and drives `sr_out` as `sr_in` with bits 28, 29 and 30 set.
- R8: `taken` goes high for exactly one cycle, in the cycle after the edge that accepts the event. Every save register and `redirect_pc` already hold their new values in that cycle. Exception requests present during that cycle are ignored.
- R9: After reset, `taken` is 0 and every save, code and redirect output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | 32 | PC of the instruction at the exception point |
| next_pc | input | 32 | PC of the following instruction |
| branch_pc | input | 32 | PC of the delayed branch owning the current slot |
| sr_in | input | 32 | Current status register |
| vbr | input | 32 | Vector base |
| slot_priv_req | input | 1 | Privileged instruction decoded in a delay slot |
| brk_req | input | 1 | Break condition met |
| brk_post | input | 1 | 1 = break after execution, 0 = before |
| mem_req | input | 1 | Data access in flight |
| mem_size | input | 2 | 0 byte, 1 word, 2 longword |
| mem_addr | input | 32 | Data access address |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_blk_override | input | 1 | Lets NMI through while the block bit is set |
| taken | output | 1 | One-cycle entry / flush pulse |
| redirect_pc | output | 32 | New fetch address |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status |
| sr_out | output | 32 | Status value for the entry |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| intevt2 | output | 12 | Second interrupt event code |

## Verification
The hardest situation to reach is a held NMI competing with every synchronous exception while those exceptions are themselves being retired one per entry. The bench sets up this case in three steps. First it raises the NMI edge while the block bit is 1, so the NMI sits pending. Then, in a single cycle, it clears the block bit and asserts all three exception sources. From there it removes each source after its entry, so the remaining events are taken one after another in the order R6 requires. The bench also checks that the dead cycle after each entry takes nothing and that `expevt` survives the final NMI entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 12;
    localparam int N_EV   = 4;

    localparam int SR_BLK = 28;
    localparam int SR_BNK = 29;
    localparam int SR_PRV = 30;

    typedef enum logic [1:0] {
        EV_ADDR = 2'd0,
        EV_SLOT = 2'd1,
        EV_BRK  = 2'd2,
        EV_NMI  = 2'd3
    } ev_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    localparam logic [CODE_W-1:0] CODE_ADDR = 12'h5C0;
    localparam logic [CODE_W-1:0] CODE_SLOT = 12'h1A0;
    localparam logic [CODE_W-1:0] CODE_BRK  = 12'h1E0;
    localparam logic [CODE_W-1:0] CODE_NMI  = 12'h1C0;

    localparam logic [XLEN-1:0] OFF_EXC = 32'h100;
    localparam logic [XLEN-1:0] OFF_INT = 32'h600;
endpackage

// File: rtl/exc_align_check.sv
module exc_align_check
    import exc_entry_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          access,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    output logic          misaligned
);
    always_comb begin
        misaligned = 1'b0;
        if (access) begin
            unique case (size)
                SZ_WORD: misaligned = addr[0];
                SZ_LONG: misaligned = |addr[1:0];
                default: misaligned = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (access && size == SZ_BYTE)
            assert_byte_never_R1: assert (!misaligned);
    end
endmodule

// File: rtl/exc_nmi_catch.sv
module exc_nmi_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clear,
    output logic pending
);
    logic pin_q;
    logic rise;

    assign rise = pin & ~pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            pin_q   <= pin;
            pending <= rise | (pending & ~clear);
        end
    end

    assert_edge_caught_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin && !pin_q) |=> pending);
    assert_pending_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> pending);
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_entry_pkg::*;
#(
    parameter int N = N_EV
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] winner,
    output logic                 any
);
    localparam int IW = $clog2(N);

    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;
    generate
        for (genvar g = 1; g < N; g++) begin : g_chain
            assign blocked[g] = blocked[g-1] | req[g-1];
        end
    endgenerate

    assign grant = req & ~blocked;
    assign any   = |req;

    always_comb begin
        winner = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) winner = IW'(i);
        end
    end

    always_comb begin
        assert_one_winner_R6: assert ($onehot0(grant));
        if (any) assert_low_index_wins_R6: assert (grant[winner] && (req & ((N'(1) << winner) - N'(1))) == '0);
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   branch_pc,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   vbr,
    input  logic              slot_priv_req,
    input  logic              brk_req,
    input  logic              brk_post,
    input  logic              mem_req,
    input  logic [1:0]        mem_size,
    input  logic [XLEN-1:0]   mem_addr,
    input  logic              nmi_pin,
    input  logic              nmi_blk_override,
    output logic              taken,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   sr_out,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic [CODE_W-1:0] intevt2
);
    localparam int IW = $clog2(N_EV);
    localparam logic [XLEN-1:0] ENTRY_SET =
        (XLEN'(1) << SR_BLK) | (XLEN'(1) << SR_BNK) | (XLEN'(1) << SR_PRV);

    typedef enum logic {ST_RUN, ST_ENTER} st_e;
    st_e state, state_nx;

    logic            addr_err;
    logic            nmi_pend;
    logic            nmi_ok;
    logic [N_EV-1:0] req;
    logic [N_EV-1:0] grant;
    logic [IW-1:0]   winner;
    logic            any_req;
    logic            accept;
    logic            nmi_accept;
    ev_e             kind;

    logic [XLEN-1:0]   sel_pc;
    logic [XLEN-1:0]   sel_off;
    logic [CODE_W-1:0] sel_code;

    exc_align_check #(.AW(XLEN)) u_align (
        .access     (mem_req),
        .size       (mem_size),
        .addr       (mem_addr),
        .misaligned (addr_err)
    );

    exc_nmi_catch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (nmi_pin),
        .clear   (nmi_accept),
        .pending (nmi_pend)
    );

    assign nmi_ok = nmi_pend & (~sr_in[SR_BLK] | nmi_blk_override);

    always_comb begin
        req          = '0;
        req[EV_ADDR] = addr_err;
        req[EV_SLOT] = slot_priv_req & ~sr_in[SR_PRV];
        req[EV_BRK]  = brk_req;
        req[EV_NMI]  = nmi_ok;
    end

    exc_prio_arb #(.N(N_EV)) u_arb (
        .req    (req),
        .grant  (grant),
        .winner (winner),
        .any    (any_req)
    );

    assign kind       = ev_e'(winner);
    assign accept     = (state == ST_RUN) && any_req;
    assign nmi_accept = accept && grant[EV_NMI];

    always_comb begin
        unique case (kind)
            EV_ADDR: begin sel_pc = cur_pc;    sel_code = CODE_ADDR; sel_off = OFF_EXC; end
            EV_SLOT: begin sel_pc = branch_pc; sel_code = CODE_SLOT; sel_off = OFF_EXC; end
            EV_BRK:  begin
                sel_pc   = brk_post ? next_pc : cur_pc;
                sel_code = CODE_BRK;
                sel_off  = OFF_EXC;
            end
            EV_NMI:  begin sel_pc = next_pc;   sel_code = CODE_NMI;  sel_off = OFF_INT; end
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (accept) state_nx = ST_ENTER;
            ST_ENTER: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    assign taken = (state == ST_ENTER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_pc <= '0;
            spc         <= '0;
            ssr         <= '0;
            sr_out      <= '0;
            expevt      <= '0;
            intevt      <= '0;
            intevt2     <= '0;
        end else if (accept) begin
            redirect_pc <= vbr + sel_off;
            spc         <= sel_pc;
            ssr         <= sr_in;
            sr_out      <= sr_in | ENTRY_SET;
            if (kind == EV_NMI) begin
                intevt  <= sel_code;
                intevt2 <= sel_code;
            end else begin
                expevt  <= sel_code;
            end
        end
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);
    assert_entry_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (sr_out[SR_BLK] && sr_out[SR_BNK] && sr_out[SR_PRV]));
    assert_nmi_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && $past(nmi_accept)) |-> (redirect_pc == $past(vbr) + OFF_INT && intevt == intevt2));
    assert_exc_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !$past(nmi_accept)) |-> (redirect_pc == $past(vbr) + OFF_EXC));
    assert_nmi_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_in[SR_BLK] && !nmi_blk_override) |-> !nmi_accept);
endmodule

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc, next_pc, branch_pc, sr_in, vbr, mem_addr;
    logic        slot_priv_req, brk_req, brk_post, mem_req, nmi_pin, nmi_blk_override;
    logic [1:0]  mem_size;
    logic        taken;
    logic [31:0] redirect_pc, spc, ssr, sr_out;
    logic [11:0] expevt, intevt, intevt2;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    exc_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .next_pc(next_pc), .branch_pc(branch_pc),
        .sr_in(sr_in), .vbr(vbr), .slot_priv_req(slot_priv_req), .brk_req(brk_req),
        .brk_post(brk_post), .mem_req(mem_req), .mem_size(mem_size), .mem_addr(mem_addr),
        .nmi_pin(nmi_pin), .nmi_blk_override(nmi_blk_override), .taken(taken),
        .redirect_pc(redirect_pc), .spc(spc), .ssr(ssr), .sr_out(sr_out),
        .expevt(expevt), .intevt(intevt), .intevt2(intevt2)
    );

    localparam logic [31:0] ENTRY_BITS = 32'h7000_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        slot_priv_req = 0; brk_req = 0; brk_post = 0; mem_req = 0;
        mem_size = 0; mem_addr = 0; nmi_blk_override = 0;
    endtask

    // reference model of one accepted entry
    task automatic expect_entry(input string req, input logic [31:0] pc_exp,
                                input logic [11:0] code, input logic is_nmi,
                                input logic [31:0] sr_seen, input logic [31:0] vb);
        chk({req, " taken"}, 32'(taken), 32'd1);
        chk({req, " spc"}, spc, pc_exp);
        chk({req, " vector"}, redirect_pc, vb + (is_nmi ? 32'h600 : 32'h100));
        chk({req, " code"}, 32'(is_nmi ? intevt : expevt), 32'(code));
        if (is_nmi) chk({req, " intevt2"}, 32'(intevt2), 32'(code));
        chk("R7 ssr", ssr, sr_seen);
        chk("R7 sr_out", sr_out, sr_seen | ENTRY_BITS);
    endtask

    task automatic t_reset();
        chk("R9 taken", 32'(taken), 0);
        chk("R9 spc", spc, 0);
        chk("R9 redirect", redirect_pc, 0);
        chk("R9 ssr", ssr, 0);
        chk("R9 codes", {8'h0, expevt, intevt}, 0);
    endtask

    task automatic t_align();
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                logic err;
                err = (sz == 1) ? off[0] : (sz == 2) ? (off != 0) : 1'b0;
                mem_req = 1; mem_size = 2'(sz); mem_addr = 32'h2000_0000 + 32'(off);
                cur_pc = 32'h0000_1000 + 32'(sz * 16 + off * 2);
                @(negedge clk);
                quiet();
                if (err) expect_entry("R1 misaligned", cur_pc, 12'h5C0, 0, sr_in, vbr);
                else     chk("R1 aligned no entry", 32'(taken), 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_slot();
        sr_in = 32'h4000_0000; slot_priv_req = 1; branch_pc = 32'h0000_3330;
        @(negedge clk);
        chk("R2 privileged mode ignored", 32'(taken), 0);
        @(negedge clk);
        chk("R2 privileged mode ignored later", 32'(taken), 0);
        sr_in = 32'h0000_00F0;
        @(negedge clk);
        quiet();
        expect_entry("R2 slot fault", branch_pc, 12'h1A0, 0, 32'h0000_00F0, vbr);
        @(negedge clk);
    endtask

    task automatic t_brk();
        brk_req = 1; brk_post = 0; cur_pc = 32'h0000_5000; next_pc = 32'h0000_5002;
        @(negedge clk);
        quiet();
        expect_entry("R3 pre break", 32'h0000_5000, 12'h1E0, 0, sr_in, vbr);
        @(negedge clk);
        brk_req = 1; brk_post = 1;
        @(negedge clk);
        quiet();
        expect_entry("R3 post break", 32'h0000_5002, 12'h1E0, 0, sr_in, vbr);
        @(negedge clk);
    endtask

    task automatic t_pulse();
        brk_req = 1;
        @(negedge clk);
        chk("R8 pulse first", 32'(taken), 1);
        cur_pc = 32'h0000_7770;
        @(negedge clk);
        quiet();
        chk("R8 pulse ends", 32'(taken), 0);
        chk("R8 request during entry ignored", spc, 32'h0000_5000);
        @(negedge clk);
    endtask

    task automatic t_nmi();
        logic [11:0] ex_before;
        ex_before = expevt;
        sr_in = 32'h0000_00F0; next_pc = 32'h0000_8002; nmi_pin = 1;
        @(negedge clk);
        chk("R4 latency", 32'(taken), 0);
        @(negedge clk);
        expect_entry("R4 nmi", 32'h0000_8002, 12'h1C0, 1, 32'h0000_00F0, vbr);
        chk("R4 expevt unchanged", 32'(expevt), 32'(ex_before));
        nmi_pin = 0;
        @(negedge clk);
    endtask

    task automatic t_nmi_block();
        sr_in = 32'h1000_0000; nmi_pin = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R5 held while blocked", 32'(taken), 0);
        end
        nmi_pin = 0; sr_in = 32'h0;
        @(negedge clk);
        expect_entry("R5 released", next_pc, 12'h1C0, 1, 32'h0, vbr);
        @(negedge clk);
        sr_in = 32'h1000_0000; nmi_blk_override = 1; nmi_pin = 1;
        @(negedge clk);
        @(negedge clk);
        expect_entry("R5 override", next_pc, 12'h1C0, 1, 32'h1000_0000, vbr);
        nmi_pin = 0; quiet(); sr_in = 0;
        @(negedge clk);
    endtask

    task automatic t_prio();
        sr_in = 32'h1000_0000; nmi_pin = 1;
        @(negedge clk);
        nmi_pin = 0;
        sr_in = 32'h0; vbr = 32'h8000_0000;
        mem_req = 1; mem_size = 2'd2; mem_addr = 32'h3;
        slot_priv_req = 1; brk_req = 1; brk_post = 0;
        cur_pc = 32'h0000_9000; next_pc = 32'h0000_9002; branch_pc = 32'h0000_8FFC;
        @(negedge clk);
        expect_entry("R6 first address error", 32'h0000_9000, 12'h5C0, 0, 0, vbr);
        mem_req = 0;
        @(negedge clk);
        chk("R6 gap", 32'(taken), 0);
        @(negedge clk);
        expect_entry("R6 second slot fault", 32'h0000_8FFC, 12'h1A0, 0, 0, vbr);
        slot_priv_req = 0;
        @(negedge clk);
        @(negedge clk);
        expect_entry("R6 third break", 32'h0000_9000, 12'h1E0, 0, 0, vbr);
        brk_req = 0;
        @(negedge clk);
        @(negedge clk);
        expect_entry("R6 last nmi", 32'h0000_9002, 12'h1C0, 1, 0, vbr);
        chk("R6 expevt kept", 32'(expevt), 32'h1E0);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        quiet();
        nmi_pin = 0; cur_pc = 0; next_pc = 0; branch_pc = 0;
        sr_in = 0; vbr = 32'h0C00_0000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_align();
        t_slot();
        t_brk();
        t_pulse();
        t_nmi();
        t_nmi_block();
        t_prio();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule